// File: doc/BRIEF.md
# Mailbox Command Engine with Microsecond Timer

This block executes host requests placed in a two-word mailbox. A one-cycle trigger marks the request words as valid. The block captures them and decodes word 0 in the next cycle. Word 0 packs a 16-bit command: the upper byte is the class and the lower byte is the operation within that class. It also packs a 16-bit sequence number and a 16-bit flag field.

The decoded request can produce two kinds of effect. The first is a generic acknowledge. It does not depend on the command, and it raises a "message read" set request toward the host doorbell. The second is the timer-control command. It arms, re-arms or cancels a one-shot countdown that runs on an external microsecond strobe. The duration of the countdown comes from word 1.

When the countdown expires, the block raises a set request for the timer-expiry doorbell bit. The doorbell register that receives these requests ORs them in, so the bits already held there are kept. Every other command code is accepted and does nothing.

The outputs are one-cycle set-bit requests on a doorbell-wide vector. Doorbell bits are numbered from the most significant end. "Message read" is bit 1 and timer expiry is bit 14 in that numbering. With the default 64-bit vector, these are LSB-indexed positions 62 and 49.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After reset `dbell_set_o` is all zero, and no timer expiry occurs until a timer start has been executed; only positions 62 and 49 (default width) are ever set.
- R2: A request whose word 0 bit 41 (flag 0x0200 in the flag field, bits 47:32) is set drives `dbell_set_o[62]` high for exactly one cycle, two clock edges after the edge that samples the trigger, for any command code.
- R3: Command code 0xD401 (word 0 bits 15:0) with flag 0x0001 (word 0 bit 32) loads the low `TIMER_W` bits of word 1 as a duration D. `dbell_set_o[49]` then pulses after the max(D,1)-th microsecond strobe that follows the executing edge. A strobe sampled on the executing edge itself is not counted.
- R4: A start with D = 0 expires on the first strobe after it executes.
- R5: Command 0xD401 with flag 0x0002 (word 0 bit 33) cancels a running countdown, and no expiry follows.
- R6: With flags 0x0001 and 0x0002 both set, the start is applied and then the stop, so the timer ends up idle and does not expire.
- R7: A start while the countdown runs discards the old count and re-arms with the new duration.
- R8: Any command code other than 0xD401 leaves the countdown untouched, even with its start or stop flags set. The sequence number (bits 31:16) never affects behaviour.
- R9: Triggers on consecutive cycles are each executed, one per cycle, in arrival order; none is lost.
- R10: An expiry request lasts one cycle and does not repeat until another start is executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | One-cycle trigger: request words are valid |
| req_word0_i | input | WORD_W | Request word 0: command, sequence, flags |
| req_word1_i | input | WORD_W | Request word 1: timer duration in microseconds |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| dbell_set_o | output | DBELL_W | One-cycle host doorbell set-bit requests |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume that the microsecond input behaves as a strobe, so that an expiry can always be traced back to a strobe in the previous cycle. The stimulus drives all inputs on the falling edge, and it starts them before reset is released. Strobes are one cycle wide with an idle cycle after each one. Triggers are either isolated or issued back to back on purpose, and a cycle-level reference model tracks both cases.

// File: rtl/mbox_cmd_pkg.sv
package mbox_cmd_pkg;
   // field positions inside request word 0
   localparam int CMD_LSB = 0;
   localparam int SEQ_LSB = 16;
   localparam int FLG_LSB = 32;
   localparam int HDR_W   = 48;

   // flag bits inside the flag field
   localparam int FLG_START = 0;
   localparam int FLG_STOP  = 1;
   localparam int FLG_ACK   = 9;

   // timer control command: class 0xD4, operation 0x01
   localparam logic [7:0] CLS_TIMER = 8'hD4;
   localparam logic [7:0] OP_TIMER  = 8'h01;

   // doorbell bits, numbered from the most significant end
   localparam int MSB_MSG_READ  = 1;
   localparam int MSB_TIMER_EXP = 14;

   typedef struct packed {
      logic [15:0] flags;
      logic [15:0] seq;
      logic [7:0]  cls;
      logic [7:0]  op;
   } req_hdr_t;

   function automatic req_hdr_t split_hdr(input logic [HDR_W-1:0] w);
      req_hdr_t h;
      h.op    = w[CMD_LSB +: 8];
      h.cls   = w[CMD_LSB+8 +: 8];
      h.seq   = w[SEQ_LSB +: 16];
      h.flags = w[FLG_LSB +: 16];
      return h;
   endfunction
endpackage

// File: rtl/mbox_req_stage.sv
module mbox_req_stage #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic [WORD_W-1:0] w0_i,
   input  logic [WORD_W-1:0] w1_i,
   output logic              vld_o,
   output logic [WORD_W-1:0] w0_o,
   output logic [WORD_W-1:0] w1_o
);
   // single holding stage that drains every cycle, so back-to-back
   // triggers are executed in order without loss
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         w0_o  <= '0;
         w1_o  <= '0;
      end else begin
         vld_o <= trig_i;
         if (trig_i) begin
            w0_o <= w0_i;
            w1_o <= w1_i;
         end
      end
   end
endmodule

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode
   import mbox_cmd_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int TIMER_W = 32
) (
   input  logic               vld_i,
   input  logic [WORD_W-1:0]  w0_i,
   input  logic [WORD_W-1:0]  w1_i,
   output logic               ack_o,
   output logic               start_o,
   output logic               stop_o,
   output logic [TIMER_W-1:0] dur_o
);
   req_hdr_t hdr;
   logic     is_timer;
   logic     unused_bits;

   assign hdr      = split_hdr(w0_i[HDR_W-1:0]);
   assign is_timer = (hdr.cls == CLS_TIMER) && (hdr.op == OP_TIMER);

   always_comb begin
      ack_o   = vld_i && hdr.flags[FLG_ACK];
      start_o = vld_i && is_timer && hdr.flags[FLG_START];
      stop_o  = vld_i && is_timer && hdr.flags[FLG_STOP];
   end

   generate
      if (WORD_W > HDR_W) begin : g_w0_top
         assign unused_bits = ^{hdr.seq, w0_i[WORD_W-1:HDR_W], w1_i};
      end else begin : g_w0_exact
         assign unused_bits = ^{hdr.seq, w1_i};
      end

      if (TIMER_W >= WORD_W) begin : g_dur_ext
         assign dur_o = TIMER_W'(w1_i);
      end else begin : g_dur_cut
         assign dur_o = w1_i[TIMER_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/mbox_us_timer.sv
module mbox_us_timer #(
   parameter int TIMER_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic [TIMER_W-1:0] dur_i,
   input  logic               tick_i,
   output logic               expire_o
);
   localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

   logic               run_q;
   logic [TIMER_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cnt_q    <= '0;
         expire_o <= 1'b0;
      end else begin
         expire_o <= 1'b0;
         if (start_i || stop_i) begin
            // start first, stop second: both together leave it idle
            if (start_i) begin
               run_q <= 1'b1;
               cnt_q <= dur_i;
            end
            if (stop_i) begin
               run_q <= 1'b0;
            end
         end else if (run_q && tick_i) begin
            if (cnt_q <= ONE) begin
               run_q    <= 1'b0;
               expire_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
   import mbox_cmd_pkg::*;
#(
   parameter int WORD_W  = 64,
   parameter int TIMER_W = 32,
   parameter int DBELL_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [WORD_W-1:0]  req_word0_i,
   input  logic [WORD_W-1:0]  req_word1_i,
   input  logic               us_tick_i,
   output logic [DBELL_W-1:0] dbell_set_o
);
   localparam int ACK_POS = DBELL_W - 1 - MSB_MSG_READ;
   localparam int EXP_POS = DBELL_W - 1 - MSB_TIMER_EXP;

   generate
      if (WORD_W < HDR_W) begin : g_bad_word
         $error("WORD_W must hold the 48-bit request header");
      end
      if (DBELL_W <= MSB_TIMER_EXP) begin : g_bad_dbell
         $error("DBELL_W too narrow for the doorbell bits");
      end
      if (TIMER_W < 1) begin : g_bad_timer
         $error("TIMER_W must be positive");
      end
   endgenerate

   logic               stg_vld;
   logic [WORD_W-1:0]  stg_w0;
   logic [WORD_W-1:0]  stg_w1;
   logic               exec_ack;
   logic               exec_start;
   logic               exec_stop;
   logic [TIMER_W-1:0] exec_dur;
   logic               ack_q;
   logic               expire;

   mbox_req_stage #(.WORD_W(WORD_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .trig_i(req_valid_i),
      .w0_i  (req_word0_i),
      .w1_i  (req_word1_i),
      .vld_o (stg_vld),
      .w0_o  (stg_w0),
      .w1_o  (stg_w1)
   );

   mbox_cmd_decode #(.WORD_W(WORD_W), .TIMER_W(TIMER_W)) u_dec (
      .vld_i  (stg_vld),
      .w0_i   (stg_w0),
      .w1_i   (stg_w1),
      .ack_o  (exec_ack),
      .start_o(exec_start),
      .stop_o (exec_stop),
      .dur_o  (exec_dur)
   );

   mbox_us_timer #(.TIMER_W(TIMER_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (exec_start),
      .stop_i  (exec_stop),
      .dur_i   (exec_dur),
      .tick_i  (us_tick_i),
      .expire_o(expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= exec_ack;
   end

   always_comb begin
      dbell_set_o          = '0;
      dbell_set_o[ACK_POS] = ack_q;
      dbell_set_o[EXP_POS] = expire;
   end
endmodule

// File: rtl/mbox_cmd_engine_chk.sv
module mbox_cmd_engine_chk #(
   parameter int WORD_W  = 64,
   parameter int DBELL_W = 64,
   parameter int ACK_POS = 62,
   parameter int EXP_POS = 49
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid_i,
   input logic [WORD_W-1:0]  req_word0_i,
   input logic               us_tick_i,
   input logic               exec_stop,
   input logic [DBELL_W-1:0] dbell_set_o
);
   localparam logic [DBELL_W-1:0] LEGAL =
      (DBELL_W'(1) << ACK_POS) | (DBELL_W'(1) << EXP_POS);

   // R1: only the two doorbell positions are ever requested
   assert_legal_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dbell_set_o & ~LEGAL) == '0);

   // R2: an acknowledge flag produces the message-read request two edges later
   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_word0_i[41]) |=> ##1 dbell_set_o[ACK_POS]);

   // R2: a message-read request always has a flagged trigger behind it
   assert_ack_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dbell_set_o[ACK_POS] |-> ($past(req_valid_i, 2) && $past(req_word0_i[41], 2)));

   // R3: expiry is always caused by a strobe
   assert_exp_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dbell_set_o[EXP_POS] |-> $past(us_tick_i));

   // R5: an executed stop is never followed by an expiry
   assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stop |=> !dbell_set_o[EXP_POS]);

   // R10: expiry is a single-cycle request
   assert_exp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dbell_set_o[EXP_POS] |=> !dbell_set_o[EXP_POS]);
endmodule

bind mbox_cmd_engine mbox_cmd_engine_chk #(
   .WORD_W (WORD_W),
   .DBELL_W(DBELL_W),
   .ACK_POS(ACK_POS),
   .EXP_POS(EXP_POS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid_i(req_valid_i),
   .req_word0_i(req_word0_i),
   .us_tick_i  (us_tick_i),
   .exec_stop  (exec_stop),
   .dbell_set_o(dbell_set_o)
);

// File: tb/tb_mbox_cmd_engine.sv
module tb_mbox_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] word0 = '0;
   logic [63:0] word1 = '0;
   logic        us_tick = 1'b0;
   logic [63:0] dbell_set;

   int checks = 0;
   int errors = 0;
   int ack_cnt = 0;
   int exp_cnt = 0;

   // reference model state
   logic        m_pv = 1'b0;
   logic [63:0] m_w0 = '0;
   logic [63:0] m_w1 = '0;
   logic        m_run = 1'b0;
   longint      m_cnt = 0;
   logic [63:0] m_out = '0;

   always #10 clk = ~clk;

   mbox_cmd_engine dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid_i(req_valid),
      .req_word0_i(word0),
      .req_word1_i(word1),
      .us_tick_i  (us_tick),
      .dbell_set_o(dbell_set)
   );

   // behavioural cycle model, stepped on each rising edge
   always @(posedge clk) begin
      logic [63:0] nxt;
      if (!rst_n) begin
         m_pv = 0; m_run = 0; m_cnt = 0; m_out = '0;
      end else begin
         nxt = '0;
         if (m_pv && m_w0[41]) nxt[62] = 1'b1;
         if (m_pv && m_w0[15:0] == 16'hD401 && (m_w0[32] || m_w0[33])) begin
            if (m_w0[32]) begin m_run = 1; m_cnt = longint'(m_w1[31:0]); end
            if (m_w0[33]) m_run = 0;
         end else if (m_run && us_tick) begin
            if (m_cnt <= 1) begin m_run = 0; nxt[49] = 1'b1; end
            else m_cnt = m_cnt - 1;
         end
         m_out = nxt;
         m_pv  = req_valid;
         if (req_valid) begin m_w0 = word0; m_w1 = word1; end
      end
   end

   // per-cycle comparison and pulse counting
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (dbell_set !== m_out) begin
            errors++;
            $display("FAIL R2/R3 model compare: got %h expected %h", dbell_set, m_out);
         end
         if (dbell_set[62]) ack_cnt++;
         if (dbell_set[49]) exp_cnt++;
      end
   end

   task automatic check_int(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [63:0] hdr(input logic [15:0] cmd, input logic [15:0] flg,
                                       input logic [15:0] seq);
      return {16'h0, flg, seq, cmd};
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [63:0] w0, input logic [63:0] w1);
      req_valid = 1'b1; word0 = w0; word1 = w1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         us_tick = 1'b1;
         @(negedge clk);
         us_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic run_tests();
      int base;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      checks++;
      if (dbell_set !== '0) begin
         errors++;
         $display("FAIL R1 reset value: got %h expected 0", dbell_set);
      end
      tick(5); idle(2);
      check_int(exp_cnt, 0, "R1 no expiry before start");

      // R2 + R8: acknowledge on a non-timer command
      send(hdr(16'hD701, 16'h0200, 16'h1234), 64'd0); idle(3);
      check_int(ack_cnt, 1, "R2 ack on other command");
      tick(3); idle(2);
      check_int(exp_cnt, 0, "R8 other command no timer");

      // R3: duration 3
      base = exp_cnt;
      send(hdr(16'hD401, 16'h0001, 16'h0007), 64'd3); idle(2);
      tick(2); idle(2);
      check_int(exp_cnt, base, "R3 not yet expired");
      tick(1); idle(2);
      check_int(exp_cnt, base + 1, "R3 expired on third tick");
      tick(4); idle(2);
      check_int(exp_cnt, base + 1, "R10 no repeat");

      // R4: duration 0
      base = exp_cnt;
      send(hdr(16'hD401, 16'h0001, 16'h0000), 64'd0); idle(2);
      tick(1); idle(2);
      check_int(exp_cnt, base + 1, "R4 zero expires on first tick");

      // R5: stop
      base = exp_cnt;
      send(hdr(16'hD401, 16'h0001, 16'h0000), 64'd5); idle(2);
      tick(2);
      send(hdr(16'hD401, 16'h0002, 16'h0000), 64'd0); idle(2);
      tick(8); idle(2);
      check_int(exp_cnt, base, "R5 stopped timer silent");

      // R6: start and stop together
      send(hdr(16'hD401, 16'h0003, 16'h0000), 64'd2); idle(2);
      tick(5); idle(2);
      check_int(exp_cnt, base, "R6 start+stop leaves idle");

      // R7: restart
      send(hdr(16'hD401, 16'h0001, 16'h0000), 64'd10); idle(2);
      tick(2);
      send(hdr(16'hD401, 16'h0001, 16'h0000), 64'd2); idle(2);
      tick(1); idle(2);
      check_int(exp_cnt, base, "R7 new duration not yet done");
      tick(1); idle(2);
      check_int(exp_cnt, base + 1, "R7 re-armed expiry");
      tick(10); idle(2);
      check_int(exp_cnt, base + 1, "R7 old count discarded");

      // R8: near-miss codes with timer flags
      base = exp_cnt;
      send(hdr(16'hD402, 16'h0001, 16'h0000), 64'd1); idle(2);
      send(hdr(16'hC401, 16'h0001, 16'h0000), 64'd1); idle(2);
      tick(3); idle(2);
      check_int(exp_cnt, base, "R8 other codes ignored");
      // R8: unknown code does not cancel a running countdown
      send(hdr(16'hD401, 16'h0001, 16'hFFFF), 64'd3); idle(2);
      tick(1);
      send(hdr(16'hD3FF, 16'h0002, 16'h0000), 64'd0); idle(2);
      tick(2); idle(2);
      check_int(exp_cnt, base + 1, "R8 running timer untouched");

      // R9: back-to-back triggers
      base = exp_cnt;
      send(hdr(16'hD101, 16'h0200, 16'h0001), 64'd0);
      send(hdr(16'hD401, 16'h0201, 16'h0002), 64'd1); idle(3);
      check_int(ack_cnt, 3, "R9 both acks seen");
      tick(1); idle(2);
      check_int(exp_cnt, base + 1, "R9 second request executed");

      // R3: only low 32 bits of word 1 count
      base = exp_cnt;
      send(hdr(16'hD401, 16'h0001, 16'h0000), 64'h1_0000_0002); idle(2);
      tick(1); idle(2);
      check_int(exp_cnt, base, "R3 truncated duration pending");
      tick(1); idle(2);
      check_int(exp_cnt, base + 1, "R3 truncated duration expired");
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule